// File: doc/BRIEF.md
# Multi-mode serial data input receiver

This block is the receive front end of an audio decoder's serial ports. It takes the raw pins of a control port and a file-data port: two active-low selects, a shared serial clock with its data line, and a second data line with its own clock and a byte-sync strobe. It samples them on the system clock through synchronizers. Depending on a two-bit mode, it decides on each cycle whether the control port is addressed or whether file data is flowing. File-data bits are shifted in MSB first, and each finished byte is presented for one clock with a valid strobe.

The four modes differ in where file data arrives and in what event realigns byte boundaries. In compat mode the byte-sync strobe aligns bytes. In new mode and passive mode the falling edge of the data select aligns bytes. In shared mode the rising edge of the single select aligns bytes. A software reset clears only the error flag and leaves byte alignment untouched. Both selects low at once is a protocol error that is recorded and blocks data. The mode input is taken in only while both selects are high.

Top module: `sdi_rx`

## Requirements
- R1: After hardware reset, byte_vld_o, err_o and ctrl_sel_o are 0.
- R2: ctrl_sel_o is 1 while cs_ni is low, in every mode. Bits clocked on si_i/sclk_i while only the control select is low produce no byte.
- R3: Mode 0 (compat): file data is always selected and is sampled from sdata_i on rising dclk_i. A byte starts only on a bit whose sampling edge sees bsync_i high. Bits that arrive with bsync_i low at a byte start are dropped.
- R4: In mode 0, bsync_i held high across several bytes and dropped before the last bit of the last byte yields one byte per 8 bits.
- R5: Mode 1 (new): file data is sampled from si_i on rising sclk_i while dcs_ni is low. Each falling edge of dcs_ni realigns.
- R6: Mode 2 (shared): file data is sampled from si_i on rising sclk_i while cs_ni is high. Each rising edge of cs_ni realigns.
- R7: Mode 3 (passive): file data is sampled from sdata_i on rising dclk_i while dcs_ni is low. Each falling edge of dcs_ni realigns.
- R8: Bytes are assembled MSB first. byte_vld_o is a one-cycle pulse after the 8th bit since alignment, with byte_o holding the byte.
- R9: An alignment event discards a partial byte. If the event falls on the same cycle as a sampling edge, that bit becomes bit 7 of a new byte.
- R10: A soft_rst_i pulse clears err_o and does not disturb the bit count of a byte in progress.
- R11: While cs_ni and dcs_ni are both low, err_o is set and stays set until soft_rst_i, and no bit is taken and no byte is emitted.
- R12: mode_i is loaded only while both selects are high. A change of mode_i while either select is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| mode_i | input | 2 | 0 compat, 1 new, 2 shared, 3 passive |
| soft_rst_i | input | 1 | Software reset pulse (synchronous) |
| cs_ni | input | 1 | Control select, active low |
| dcs_ni | input | 1 | Data select, active low |
| sclk_i | input | 1 | Shared serial clock |
| si_i | input | 1 | Shared serial data in |
| sdata_i | input | 1 | Dedicated file-data line |
| dclk_i | input | 1 | Clock for the dedicated data line |
| bsync_i | input | 1 | Byte-sync strobe for compat mode |
| ctrl_sel_o | output | 1 | Control port selected |
| byte_o | output | BYTE_W | Last completed file-data byte |
| byte_vld_o | output | 1 | One-cycle strobe for byte_o |
| err_o | output | 1 | Sticky select-conflict flag |

## Verification
An alignment event and a sampling edge can fall in the same system-clock cycle. The clearest case is the byte-sync strobe and the data clock rising together in compat mode. The bench first leaves a three-bit partial byte, then raises bsync_i and dclk_i on the same cycle for the first bit of a new byte. The received byte must equal the new byte exactly, which shows that alignment wins and that the coincident bit is kept as the MSB. A select conflict during sampling edges is also provoked, and both err_o and the absence of any byte strobe are checked.

// File: rtl/sdi_rx_pkg.sv
package sdi_rx_pkg;
  typedef enum logic [1:0] {
    MODE_COMPAT  = 2'd0,
    MODE_NEW     = 2'd1,
    MODE_SHARED  = 2'd2,
    MODE_PASSIVE = 2'd3
  } rx_mode_e;

  localparam int unsigned PIN_W   = 7;
  localparam int unsigned P_CS    = 0;
  localparam int unsigned P_DCS   = 1;
  localparam int unsigned P_SCLK  = 2;
  localparam int unsigned P_SI    = 3;
  localparam int unsigned P_SDATA = 4;
  localparam int unsigned P_DCLK  = 5;
  localparam int unsigned P_BSYNC = 6;
  // selects idle high, all else low
  localparam logic [PIN_W-1:0] PIN_IDLE = 7'b000_0011;
endpackage

// File: rtl/sdi_sync.sv
module sdi_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sdi_route.sv
module sdi_route
  import sdi_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [PIN_W-1:0] pins_i,
  output rx_mode_e         mode_o,
  output logic             sel_o,
  output logic             bit_o,
  output logic             strobe_o,
  output logic             align_o,
  output logic             start_ok_o,
  output logic             conflict_o
);
  logic [PIN_W-1:0] prev_q;
  rx_mode_e         mode_q;

  logic cs, dcs, sclk_rise, dclk_rise, dcs_fall, cs_rise, bsync_rise;
  logic sel;

  assign cs         = pins_i[P_CS];
  assign dcs        = pins_i[P_DCS];
  assign sclk_rise  = pins_i[P_SCLK]  & ~prev_q[P_SCLK];
  assign dclk_rise  = pins_i[P_DCLK]  & ~prev_q[P_DCLK];
  assign dcs_fall   = ~dcs & prev_q[P_DCS];
  assign cs_rise    = cs & ~prev_q[P_CS];
  assign bsync_rise = pins_i[P_BSYNC] & ~prev_q[P_BSYNC];
  assign conflict_o = ~cs & ~dcs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= PIN_IDLE;
      mode_q <= MODE_COMPAT;
    end else begin
      prev_q <= pins_i;
      if (cs && dcs) mode_q <= rx_mode_e'(mode_i);
    end
  end

  always_comb begin
    sel        = 1'b0;
    bit_o      = pins_i[P_SI];
    strobe_o   = sclk_rise;
    align_o    = 1'b0;
    start_ok_o = 1'b1;
    case (mode_q)
      MODE_COMPAT: begin
        sel        = 1'b1;
        bit_o      = pins_i[P_SDATA];
        strobe_o   = dclk_rise;
        align_o    = bsync_rise;
        start_ok_o = pins_i[P_BSYNC];
      end
      MODE_NEW: begin
        sel     = ~dcs;
        align_o = dcs_fall;
      end
      MODE_SHARED: begin
        sel     = cs;
        align_o = cs_rise;
      end
      MODE_PASSIVE: begin
        sel      = ~dcs;
        bit_o    = pins_i[P_SDATA];
        strobe_o = dclk_rise;
        align_o  = dcs_fall;
      end
      default: ;
    endcase
  end

  assign sel_o  = sel & ~conflict_o;
  assign mode_o = mode_q;
endmodule

// File: rtl/sdi_shift.sv
module sdi_shift #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              sel_i,
  input  logic              bit_i,
  input  logic              align_i,
  input  logic              start_ok_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              vld_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_eff;
  logic [BYTE_W-1:0] sh_q, sh_nxt;
  logic              take;

  assign cnt_eff = align_i ? '0 : cnt_q;
  assign take    = strobe_i & sel_i & ((cnt_eff != '0) | start_ok_i);
  assign sh_nxt  = {sh_q[BYTE_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      byte_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (take) begin
        sh_q <= sh_nxt;
        if (cnt_eff == LAST) begin
          cnt_q  <= '0;
          byte_o <= sh_nxt;
          vld_o  <= 1'b1;
        end else begin
          cnt_q <= cnt_eff + 1'b1;
        end
      end else if (align_i) begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/sdi_rx.sv
module sdi_rx
  import sdi_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BYTE_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              soft_rst_i,
  input  logic              cs_ni,
  input  logic              dcs_ni,
  input  logic              sclk_i,
  input  logic              si_i,
  input  logic              sdata_i,
  input  logic              dclk_i,
  input  logic              bsync_i,
  output logic              ctrl_sel_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              err_o
);
  logic [PIN_W-1:0] pins_raw, pins_s;
  rx_mode_e         mode_q;
  logic             sel, bit_s, strobe, align, start_ok, conflict;
  logic             cs_s, dcs_s, err_q;

  assign pins_raw = {bsync_i, dclk_i, sdata_i, si_i, sclk_i, dcs_ni, cs_ni};

  sdi_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  sdi_route i_route (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .pins_i    (pins_s),
    .mode_o    (mode_q),
    .sel_o     (sel),
    .bit_o     (bit_s),
    .strobe_o  (strobe),
    .align_o   (align),
    .start_ok_o(start_ok),
    .conflict_o(conflict)
  );

  sdi_shift #(.BYTE_W(BYTE_W)) i_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (strobe),
    .sel_i     (sel),
    .bit_i     (bit_s),
    .align_i   (align),
    .start_ok_i(start_ok),
    .byte_o    (byte_o),
    .vld_o     (byte_vld_o)
  );

  // conflict wins over a simultaneous soft reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          err_q <= 1'b0;
    else if (conflict)    err_q <= 1'b1;
    else if (soft_rst_i)  err_q <= 1'b0;
  end

  assign cs_s       = pins_s[P_CS];
  assign dcs_s      = pins_s[P_DCS];
  assign ctrl_sel_o = ~cs_s;
  assign err_o      = err_q;
endmodule

// File: rtl/sdi_rx_chk.sv
module sdi_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_s,
  input logic       dcs_s,
  input logic [1:0] mode_q,
  input logic       conflict,
  input logic       soft_rst_i,
  input logic       byte_vld_o,
  input logic       err_o
);
  assert_err_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict |=> err_o);
  assert_err_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !soft_rst_i) |=> err_o);
  assert_no_byte_in_conflict_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> !$past(conflict));
  assert_soft_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_i && !conflict) |=> !err_o);
  assert_mode_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_s && dcs_s) |=> $stable(mode_q));
  assert_vld_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);
endmodule

bind sdi_rx sdi_rx_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_s      (cs_s),
  .dcs_s     (dcs_s),
  .mode_q    (mode_q),
  .conflict  (conflict),
  .soft_rst_i(soft_rst_i),
  .byte_vld_o(byte_vld_o),
  .err_o     (err_o)
);

// File: tb/test_sdi_rx.sv
module test_sdi_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic soft_rst = 0, cs_n = 1, dcs_n = 1, sclk = 0, si = 0, sdata = 0, dclk = 0, bsync = 0;
  logic ctrl_sel, byte_vld, err;
  logic [7:0] byte_q;

  int checks = 0, failures = 0, rx_n = 0;
  bit done = 0;
  logic [7:0] rx_buf [256];

  always #4 clk = ~clk;

  sdi_rx i_sdi_rx (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .soft_rst_i(soft_rst),
    .cs_ni(cs_n), .dcs_ni(dcs_n), .sclk_i(sclk), .si_i(si), .sdata_i(sdata),
    .dclk_i(dclk), .bsync_i(bsync), .ctrl_sel_o(ctrl_sel), .byte_o(byte_q),
    .byte_vld_o(byte_vld), .err_o(err)
  );

  always @(negedge clk) if (byte_vld) begin
    rx_buf[rx_n[7:0]] = byte_q;
    rx_n++;
  end

  // {mode, data}
  localparam logic [9:0] VEC [8] = '{10'h1A5, 10'h23C, 10'h381, 10'h0E7,
                                     10'h101, 10'h3FE, 10'h280, 10'h06D};

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    cs_n = 1; dcs_n = 1; mode = m; tick(6);
  endtask

  task automatic bit_s(input logic b);
    si = b; tick(3); sclk = 1; tick(4); sclk = 0; tick(1);
  endtask

  task automatic bit_d(input logic b);
    sdata = b; tick(3); dclk = 1; tick(4); dclk = 0; tick(1);
  endtask

  task automatic byte_new(input logic [7:0] v);
    dcs_n = 0; tick(3);
    for (int i = 7; i >= 0; i--) bit_s(v[i]);
    tick(2); dcs_n = 1; tick(3);
  endtask

  task automatic byte_passive(input logic [7:0] v);
    dcs_n = 0; tick(3);
    for (int i = 7; i >= 0; i--) bit_d(v[i]);
    tick(2); dcs_n = 1; tick(3);
  endtask

  task automatic byte_shared(input logic [7:0] v);
    cs_n = 0; tick(3); cs_n = 1; tick(3);
    for (int i = 7; i >= 0; i--) bit_s(v[i]);
    tick(3);
  endtask

  task automatic byte_compat(input logic [7:0] v, input bit hold);
    bsync = 1;
    for (int i = 7; i >= 0; i--) begin
      if (i == 0 && !hold) bsync = 0;
      bit_d(v[i]);
    end
    tick(3);
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R3/R8 compat";
      2'd1: return "R5/R8 new";
      2'd2: return "R6/R8 shared";
      default: return "R7/R8 passive";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n0;
    tick(3);
    // R1: reset state
    chk(byte_vld, 0, "R1 vld");
    chk(err, 0, "R1 err");
    chk(ctrl_sel, 0, "R1 ctrl_sel");
    rst_n = 1; tick(4);
    chk(err, 0, "R1 err after release");

    // vector table across modes
    for (int k = 0; k < 8; k++) begin
      set_mode(VEC[k][9:8]);
      n0 = rx_n;
      case (VEC[k][9:8])
        2'd0: byte_compat(VEC[k][7:0], 0);
        2'd1: byte_new(VEC[k][7:0]);
        2'd2: byte_shared(VEC[k][7:0]);
        default: byte_passive(VEC[k][7:0]);
      endcase
      tick(4);
      chk(rx_n - n0, 1, mode_tag(VEC[k][9:8]));
      chk(rx_buf[n0[7:0]], VEC[k][7:0], mode_tag(VEC[k][9:8]));
    end

    // R2: control select
    set_mode(2'd1);
    n0 = rx_n;
    cs_n = 0; tick(4);
    chk(ctrl_sel, 1, "R2 ctrl_sel high");
    for (int i = 0; i < 8; i++) bit_s(i[0]);
    tick(3);
    chk(rx_n - n0, 0, "R2 no byte on control");
    cs_n = 1; tick(4);
    chk(ctrl_sel, 0, "R2 ctrl_sel low");

    // R9: partial byte discarded on data-select fall
    n0 = rx_n;
    dcs_n = 0; tick(3);
    for (int i = 0; i < 3; i++) bit_s(1'b1);
    dcs_n = 1; tick(3);
    byte_new(8'h3C); tick(3);
    chk(rx_n - n0, 1, "R9 count");
    chk(rx_buf[n0[7:0]], 8'h3C, "R9 data");

    // R10: soft reset mid-byte keeps bit count
    n0 = rx_n;
    dcs_n = 0; tick(3);
    for (int i = 7; i >= 4; i--) bit_s(8'h96 >> i);
    soft_rst = 1; tick(1); soft_rst = 0; tick(2);
    for (int i = 3; i >= 0; i--) bit_s(8'h96 >> i);
    tick(2); dcs_n = 1; tick(4);
    chk(rx_n - n0, 1, "R10 count");
    chk(rx_buf[n0[7:0]], 8'h96, "R10 data");

    // R11: select conflict
    n0 = rx_n;
    cs_n = 0; dcs_n = 0; tick(3);
    for (int i = 0; i < 8; i++) bit_s(1'b1);
    tick(3);
    chk(err, 1, "R11 err set");
    chk(rx_n - n0, 0, "R11 no byte");
    cs_n = 1; dcs_n = 1; tick(6);
    chk(err, 1, "R11 err sticky");
    soft_rst = 1; tick(1); soft_rst = 0; tick(2);
    chk(err, 0, "R10 soft reset clears err");

    // R12: mode change ignored while selected
    n0 = rx_n;
    dcs_n = 0; tick(3);
    mode = 2'd3; tick(3);
    for (int i = 7; i >= 0; i--) bit_s(8'h4B >> i);
    tick(2); dcs_n = 1; tick(4);
    chk(rx_n - n0, 1, "R12 count");
    chk(rx_buf[n0[7:0]], 8'h4B, "R12 data");

    // R3: compat without bsync drops bits
    set_mode(2'd0);
    n0 = rx_n;
    bsync = 0;
    for (int i = 0; i < 8; i++) bit_d(1'b1);
    tick(3);
    chk(rx_n - n0, 0, "R3 no bsync no byte");

    // R4: chunk with bsync held
    n0 = rx_n;
    byte_compat(8'h11, 1);
    byte_compat(8'h22, 1);
    byte_compat(8'h33, 0);
    tick(3);
    chk(rx_n - n0, 3, "R4 count");
    chk(rx_buf[n0[7:0]], 8'h11, "R4 b0");
    chk(rx_buf[8'(n0 + 1)], 8'h22, "R4 b1");
    chk(rx_buf[8'(n0 + 2)], 8'h33, "R4 b2");

    // R9: bsync rise coincides with sampling edge after a partial byte
    n0 = rx_n;
    bsync = 1;
    for (int i = 0; i < 3; i++) bit_d(1'b0);
    bsync = 0; tick(3);
    sdata = 1'b1; tick(3);
    bsync = 1; dclk = 1; tick(4); dclk = 0; tick(1);
    for (int i = 6; i >= 0; i--) begin
      if (i == 0) bsync = 0;
      bit_d(8'hA9 >> i);
    end
    tick(4);
    chk(rx_n - n0, 1, "R9 coincident count");
    chk(rx_buf[n0[7:0]], 8'hA9, "R9 coincident data");

    // R6: shared realign on select rise
    set_mode(2'd2);
    n0 = rx_n;
    for (int i = 0; i < 5; i++) bit_s(1'b1);
    byte_shared(8'hC3); tick(3);
    chk(rx_n - n0, 1, "R6 realign count");
    chk(rx_buf[n0[7:0]], 8'hC3, "R6 realign data");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule